// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the target-side front end of a two-wire serial bus. It oversamples the clock and data lines on the system clock and recognises bus conditions from those samples. A START is a falling data line while the clock is high, and a STOP is a rising data line while the clock is high. After each START it collects the first byte: a 7-bit address followed by a direction bit. It compares that byte with a programmed local address and, when the feature is enabled, with the all-zero broadcast (general-call) address.

On a match the block raises a selection flag and pulls the data line low to acknowledge. It then either takes in data bytes or shifts out bytes supplied by the host. For received data bytes, the acknowledge value is chosen in advance by the host. When the address does not match, the block keeps its data driver off until the bus frames a new transfer. The host sees one received byte at a time, marked by a one-cycle strobe, and supplies one byte at a time for transmission. The data line is modelled as an open-drain pair: `sda_in` is the resolved bus level, and `sda_pull` asks the pad to pull the line low.

The controller is a single state machine with these states:
- S_IDLE waits for a START.
- S_ADDR shifts in the address byte.
- S_ACK_WAIT waits for the falling clock that ends the eighth bit and then drives the acknowledge.
- S_ACK_HOLD holds the acknowledge through the ninth clock.
- S_RX shifts in data bytes.
- S_TX shifts out a data byte.
- S_MACK samples the master's acknowledge.
- S_TX_NEXT waits for the falling clock, then loads the next transmit byte.
- S_IGNORE stays silent until the next START or STOP.

The transitions are:
- Any state goes to S_ADDR on a START and to S_IDLE on a STOP.
- S_ADDR goes to S_ACK_WAIT on a match and to S_IGNORE otherwise, in both cases at the eighth rising clock.
- S_ACK_WAIT goes to S_ACK_HOLD on a falling clock.
- S_ACK_HOLD goes on a falling clock to S_TX for a read and to S_RX for a write.
- S_RX goes to S_ACK_WAIT at the eighth rising clock.
- S_TX goes to S_MACK after the eighth falling clock.
- S_MACK goes to S_TX_NEXT if the master acknowledges and to S_IGNORE if it does not.
- S_TX_NEXT goes to S_TX on a falling clock.

Top module: `i2c_slave_matcher`

## Requirements
- R1: After reset `sda_pull`, `slv_sel`, `gc_sel` and `rx_strobe` are all 0.
- R2: The address byte arrives MSB first, and its eighth bit is the direction (1 = master reads). When bits 7..1 equal `my_addr` and the byte is not 0x00, `slv_sel` rises, `rd_dir` takes the direction bit and the block pulls SDA low for the ninth clock.
- R3: When an address byte matches neither the local address nor an enabled general call, the block pulls SDA for none of that transfer's clocks, including its acknowledge clocks, and produces no `rx_strobe`.
- R4: The address byte 0x00 is a general call. With `gc_en` = 1 it is acknowledged and sets `gc_sel` with `slv_sel` = 0. With `gc_en` = 0 it is not acknowledged and raises neither flag, even when `my_addr` is 0. `slv_sel` and `gc_sel` are never both 1.
- R5: A STOP clears `slv_sel` and `gc_sel` and releases SDA. Both flags otherwise persist through the transfer's data bytes.
- R6: A repeated START clears `slv_sel` and `gc_sel`, and the following address byte is evaluated afresh.
- R7: In write mode each data byte appears on `rx_data` with a one-cycle `rx_strobe` at its eighth rising clock. The ninth clock is pulled low when `rx_nack` = 0 and left released when `rx_nack` = 1. `rx_nack` is sampled at that eighth rising clock.
- R8: In read mode the block shifts out `tx_data` MSB first, pulling SDA low for each 0 bit. The byte is captured at the falling clock that ends the address acknowledge and, after each master acknowledge, at the falling clock that ends it.
- R9: When the master does not acknowledge a transmitted byte, the block releases SDA for all further clocks until the next START or STOP.
- R10: Each line passes through a 2-flop synchronizer. Data-line changes while SCL is low are never taken as START or STOP, and `sda_pull` only ever asserts while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Resolved bus data line level |
| sda_pull | output | 1 | 1 = pull the data line low |
| my_addr | input | 7 | Programmed local address |
| gc_en | input | 1 | Answer the general-call address |
| rx_nack | input | 1 | 1 = do not acknowledge the next received data byte |
| tx_data | input | 8 | Byte to transmit in read mode |
| slv_sel | output | 1 | Selected by the local address |
| gc_sel | output | 1 | Selected by general call |
| rd_dir | output | 1 | Direction of the current selection (1 = master reads) |
| rx_data | output | 8 | Last received data byte |
| rx_strobe | output | 1 | One-cycle pulse when `rx_data` is updated |

## Verification
Two events can fall in the same clock: a repeated START and a selection flag that is already set. In that cycle the clearing of the flag and the restart of address capture coincide. The bench provokes this by addressing the block, issuing a repeated START without a STOP, and then sending a foreign address followed by the block's own address. It judges that the flag drops after the START, stays low for the foreign byte and rises again at the own address. A second coincidence is the eighth rising clock of a data byte, where the byte strobe, the acknowledge choice and the `rx_nack` sample all happen at once. The bench flips `rx_nack` between bytes and checks both the strobed byte and the acknowledge level seen on the bus.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ACK_WAIT,
        S_ACK_HOLD,
        S_RX,
        S_TX,
        S_MACK,
        S_TX_NEXT,
        S_IGNORE
    } slv_state_e;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_hi,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] lvl_p;

    assign raw = {sda_raw, scl_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_p <= '1;
        else        lvl_p <= lvl;
    end

    assign scl_hi    = lvl[0];
    assign sda_lvl   = lvl[1];
    assign scl_rise  =  lvl[0] & ~lvl_p[0];
    assign scl_fall  = ~lvl[0] &  lvl_p[0];
    assign start_det =  lvl[0] &  lvl_p[0] &  lvl_p[1] & ~lvl[1];
    assign stop_det  =  lvl[0] &  lvl_p[0] & ~lvl_p[1] &  lvl[1];

endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
    parameter int DATA_W = 8,
    localparam int ADDR_W = DATA_W - 1
) (
    input  logic [DATA_W-1:0] cap_byte,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic              gc_en,
    output logic              hit_own,
    output logic              hit_gc
);
    logic is_zero;

    assign is_zero = (cap_byte == '0);
    assign hit_gc  = gc_en & is_zero;
    assign hit_own = (cap_byte[DATA_W-1:1] == my_addr) & ~is_zero;

endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
    import i2c_slv_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = DATA_W - 1,
    localparam int CNT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_hi,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              hit_own,
    input  logic              hit_gc,
    input  logic              rx_nack,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] cap_byte,
    output logic              sda_pull,
    output logic              slv_sel,
    output logic              gc_sel,
    output logic              rd_dir,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_strobe
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    slv_state_e        state, nxt;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              ack_lo;
    logic              last_bit;

    assign cap_byte = {shreg[DATA_W-2:0], sda_lvl};
    assign last_bit = (cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = S_IDLE;
        end else if (start_det) begin
            nxt = S_ADDR;
        end else begin
            unique case (state)
                S_IDLE:     nxt = S_IDLE;
                S_ADDR:     if (scl_rise && last_bit)
                                nxt = (hit_own || hit_gc) ? S_ACK_WAIT : S_IGNORE;
                S_ACK_WAIT: if (scl_fall) nxt = S_ACK_HOLD;
                S_ACK_HOLD: if (scl_fall) nxt = rd_dir ? S_TX : S_RX;
                S_RX:       if (scl_rise && last_bit) nxt = S_ACK_WAIT;
                S_TX:       if (scl_fall && last_bit) nxt = S_MACK;
                S_MACK:     if (scl_rise) nxt = sda_lvl ? S_IGNORE : S_TX_NEXT;
                S_TX_NEXT:  if (scl_fall) nxt = S_TX;
                S_IGNORE:   nxt = S_IGNORE;
                default:    nxt = S_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            ack_lo    <= 1'b0;
            sda_pull  <= 1'b0;
            slv_sel   <= 1'b0;
            gc_sel    <= 1'b0;
            rd_dir    <= 1'b0;
            rx_data   <= '0;
            rx_strobe <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            if (stop_det || start_det) begin
                slv_sel  <= 1'b0;
                gc_sel   <= 1'b0;
                rd_dir   <= 1'b0;
                sda_pull <= 1'b0;
                cnt      <= '0;
            end else begin
                unique case (state)
                    S_ADDR: if (scl_rise) begin
                        shreg <= cap_byte;
                        cnt   <= cnt + 1'b1;
                        if (last_bit) begin
                            cnt     <= '0;
                            slv_sel <= hit_own;
                            gc_sel  <= hit_gc;
                            rd_dir  <= hit_own & cap_byte[0];
                            ack_lo  <= 1'b1;
                        end
                    end
                    S_ACK_WAIT: if (scl_fall) sda_pull <= ack_lo;
                    S_ACK_HOLD: if (scl_fall) begin
                        cnt <= '0;
                        if (rd_dir) begin
                            shreg    <= tx_data;
                            sda_pull <= ~tx_data[DATA_W-1];
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                    S_RX: if (scl_rise) begin
                        shreg <= cap_byte;
                        cnt   <= cnt + 1'b1;
                        if (last_bit) begin
                            cnt       <= '0;
                            rx_data   <= cap_byte;
                            rx_strobe <= 1'b1;
                            ack_lo    <= ~rx_nack;
                        end
                    end
                    S_TX: if (scl_fall) begin
                        if (last_bit) begin
                            sda_pull <= 1'b0;
                            cnt      <= '0;
                        end else begin
                            shreg    <= shreg << 1;
                            sda_pull <= ~shreg[DATA_W-2];
                            cnt      <= cnt + 1'b1;
                        end
                    end
                    S_TX_NEXT: if (scl_fall) begin
                        shreg    <= tx_data;
                        sda_pull <= ~tx_data[DATA_W-1];
                        cnt      <= '0;
                    end
                    S_IDLE, S_MACK, S_IGNORE: sda_pull <= 1'b0;
                    default: sda_pull <= 1'b0;
                endcase
            end
        end
    end

    // R5
    stop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!slv_sel && !gc_sel && !sda_pull));

    // R6
    rstart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!slv_sel && !gc_sel));

    // R4
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(slv_sel && gc_sel));

    // R7
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    // R3
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE || state == S_IDLE) |-> !sda_pull);

    // R10
    pull_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_hi);

endmodule

// File: rtl/i2c_slave_matcher.sv
module i2c_slave_matcher #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic              gc_en,
    input  logic              rx_nack,
    input  logic [DATA_W-1:0] tx_data,
    output logic              slv_sel,
    output logic              gc_sel,
    output logic              rd_dir,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_strobe
);
    logic              scl_hi, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              hit_own, hit_gc;
    logic [DATA_W-1:0] cap_byte;

    i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_hi    (scl_hi),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
        .cap_byte (cap_byte),
        .my_addr  (my_addr),
        .gc_en    (gc_en),
        .hit_own  (hit_own),
        .hit_gc   (hit_gc)
    );

    i2c_slv_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_hi    (scl_hi),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .hit_own   (hit_own),
        .hit_gc    (hit_gc),
        .rx_nack   (rx_nack),
        .tx_data   (tx_data),
        .cap_byte  (cap_byte),
        .sda_pull  (sda_pull),
        .slv_sel   (slv_sel),
        .gc_sel    (gc_sel),
        .rd_dir    (rd_dir),
        .rx_data   (rx_data),
        .rx_strobe (rx_strobe)
    );

endmodule

// File: tb/i2c_slave_matcher_bench.sv
module i2c_slave_matcher_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam logic [6:0] OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [6:0] my_addr = OWN;
    logic       gc_en = 1'b1;
    logic       rx_nack = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       sda_pull, slv_sel, gc_sel, rd_dir, rx_strobe;
    logic [7:0] rx_data;
    logic       sda_bus;

    int tests = 0;
    int fails = 0;
    int rx_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 1'b0;

    assign sda_bus = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_slave_matcher u_i2c_slave_matcher (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_pull(sda_pull), .my_addr(my_addr), .gc_en(gc_en),
        .rx_nack(rx_nack), .tx_data(tx_data), .slv_sel(slv_sel),
        .gc_sel(gc_sel), .rd_dir(rd_dir), .rx_data(rx_data),
        .rx_strobe(rx_strobe)
    );

    always @(posedge clk) begin
        if (rx_strobe) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
    end

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b1; waitq(Q);
    endtask

    task automatic clk_bit(input bit b, output bit seen);
        sda_m = b; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        seen = sda_bus; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] v;
        int n0;
        waitq(4);
        rst_n = 1'b1;
        waitq(4);
        // R1 reset state
        chk(!sda_pull && !slv_sel && !gc_sel && !rx_strobe, "R1",
            {sda_pull, slv_sel, gc_sel, rx_strobe}, 0);

        // R2 R3 R4 R5 sweep over all write addresses, general call enabled
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({a[6:0], 1'b0}, ack);
            chk(ack == ((a == OWN) || (a == 0)), "R2", ack, (a == OWN) || (a == 0));
            chk(slv_sel == (a == OWN), "R2", slv_sel, a == OWN);
            chk(gc_sel == (a == 0), "R4", gc_sel, a == 0);
            bus_stop();
            chk(!slv_sel && !gc_sel && !sda_pull, "R5", {slv_sel, gc_sel, sda_pull}, 0);
        end

        // R2 read direction
        tx_data = 8'hFF;
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        chk(ack && slv_sel && rd_dir, "R2", {ack, slv_sel, rd_dir}, 7);
        recv_byte(1'b0, v);
        bus_stop();

        // R4 general call disabled, and with local address 0
        gc_en = 1'b0;
        bus_start();
        send_byte(8'h00, ack);
        chk(!ack && !gc_sel && !slv_sel, "R4", {ack, gc_sel, slv_sel}, 0);
        bus_stop();
        my_addr = 7'h00;
        bus_start();
        send_byte(8'h00, ack);
        chk(!ack && !gc_sel && !slv_sel, "R4", {ack, gc_sel, slv_sel}, 0);
        bus_stop();
        my_addr = OWN;
        gc_en = 1'b1;

        // R3 non-matching address, following data byte ignored
        n0 = rx_cnt;
        bus_start();
        send_byte({7'h22, 1'b0}, ack);
        chk(!ack, "R3", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack && rx_cnt == n0, "R3", {ack, rx_cnt - n0}, 0);
        bus_stop();

        // R7 write data with chosen acknowledge; R10 SDA toggles while SCL low
        rx_nack = 1'b0;
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        for (int k = 0; k < 3; k++) begin
            sda_m = 1'b0; waitq(Q);
            sda_m = 1'b1; waitq(Q);
        end
        chk(slv_sel && !gc_sel, "R10", slv_sel, 1);
        n0 = rx_cnt;
        send_byte(8'hA5, ack);
        chk(ack, "R7", ack, 1);
        chk(rx_cnt == n0 + 1 && rx_last == 8'hA5, "R7", rx_last, 8'hA5);
        rx_nack = 1'b1;
        send_byte(8'h3C, ack);
        chk(!ack, "R7", ack, 0);
        chk(rx_cnt == n0 + 2 && rx_last == 8'h3C, "R7", rx_last, 8'h3C);
        rx_nack = 1'b0;
        chk(slv_sel, "R5", slv_sel, 1);
        bus_stop();
        chk(!slv_sel, "R5", slv_sel, 0);

        // R8 read with master ACK then NACK; R9 silence afterwards
        tx_data = 8'h96;
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        chk(ack, "R8", ack, 1);
        tx_data = 8'h41;
        recv_byte(1'b1, v);
        chk(v == 8'h96, "R8", v, 8'h96);
        recv_byte(1'b0, v);
        chk(v == 8'h41, "R8", v, 8'h41);
        recv_byte(1'b0, v);
        chk(v == 8'hFF, "R9", v, 8'hFF);
        bus_stop();

        // R6 repeated START clears selection and re-evaluates
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        chk(ack && slv_sel, "R6", slv_sel, 1);
        bus_rstart();
        chk(!slv_sel, "R6", slv_sel, 0);
        send_byte({7'h11, 1'b1}, ack);
        chk(!ack && !slv_sel, "R6", {ack, slv_sel}, 0);
        tx_data = 8'hC3;
        bus_rstart();
        send_byte({OWN, 1'b1}, ack);
        chk(ack && slv_sel && rd_dir, "R6", {ack, slv_sel, rd_dir}, 7);
        recv_byte(1'b0, v);
        chk(v == 8'hC3, "R8", v, 8'hC3);
        bus_stop();
        chk(!slv_sel && !sda_pull, "R5", {slv_sel, sda_pull}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule